// File: doc/BRIEF.md
# Configurable Pad Cell with Output-Enable Selection

This block sits between one package pin and the internal logic routing. A static configuration word picks how the pin behaves: a plain combinational input, an input captured by a flip-flop, an input held by a level-sensitive latch, a driven output, or a bidirectional pin whose driver is switched by a selectable enable. Two dedicated I/O clocks are distributed to every cell. A per-cell select picks which of them times the input register or latch.

In bidirectional mode the driver enable comes from one of twelve shared sources: two chip-wide enable pins and ten enables formed in logic, one per group of sixteen cells. A chip-wide test enable pin, active low, overrides every setting and turns the driver off. An active-low chip reset clears the input storage asynchronously. One instance is placed per pin, so ten groups of sixteen make 160 cells.

Top module: `io_cell`

## Requirements
- R1: With `cfg_mode` = 0 (combinational input), `core_in` equals `pad_i` in the same cycle and `pad_oe` is 0.
- R2: With `cfg_mode` = 1 (registered input), `core_in` shows the value `pad_i` had at the most recent rising edge of the selected I/O clock, and `pad_oe` is 0.
- R3: With `cfg_mode` = 2 (latched input), `core_in` follows `pad_i` while the selected I/O clock is high and holds the value from its falling edge while it is low, and `pad_oe` is 0.
- R4: `cfg_clk_sel` = 0 selects `io_clk[0]` and `cfg_clk_sel` = 1 selects `io_clk[1]`. Each clock has its own register and latch, so switching the select shows the storage of the newly selected clock.
- R5: With `cfg_mode` = 3 (output), `pad_oe` is 1 whenever `test_oe_n` is 1, and `core_in` reads 0.
- R6: With `cfg_mode` = 4 (bidirectional), `pad_oe` follows the source chosen by `cfg_oe_sel`. Codes 0 and 1 pick `goe[0]` and `goe[1]`. Codes 2 to 11 pick `pt_oe[code-2]`. Codes 12 to 15 give an enable of 0.
- R7: With `cfg_mode` = 4, `core_in` equals `pad_i` at all times, including while the cell drives the pad.
- R8: When `test_oe_n` is 0, `pad_oe` is 0 in every mode and for every enable source.
- R9: `pad_o` equals `core_out` while `pad_oe` is 1, and is 0 while `pad_oe` is 0.
- R10: While `rst_n` is 0, the input register and latch of both clocks are cleared at once, without waiting for a clock, so `core_in` reads 0 in modes 1 and 2.
- R11: Mode codes 5, 6 and 7 behave exactly like mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| io_clk | input | NCLK | Dedicated I/O clocks; bit 0 is the first clock, bit 1 the second |
| rst_n | input | 1 | Chip reset, active low, asynchronous clear of input storage |
| test_oe_n | input | 1 | Test enable, active low; low forces the driver off |
| goe | input | NGOE | Chip-wide output-enable pins |
| pt_oe | input | NPTOE | Logic-formed enables, one per group of cells |
| cfg_mode | input | 3 | Pin mode: 0 comb in, 1 reg in, 2 latch in, 3 out, 4 bidir, 5-7 as 0 |
| cfg_oe_sel | input | SEL_W | Enable source select for bidirectional mode |
| cfg_clk_sel | input | $clog2(NCLK) | I/O clock select for the register and latch |
| pad_i | input | 1 | Value received from the pad |
| pad_o | output | 1 | Value sent to the pad driver |
| pad_oe | output | 1 | Pad driver enable |
| core_out | input | 1 | Data from internal logic to be driven out |
| core_in | output | 1 | Data delivered to the internal routing |

## Verification
The assertions assume the configuration and `pad_i` change only away from the rising edge of `io_clk[0]`. They also assume reset is held for at least one such edge before the register check applies. The stimulus meets this by changing every input 1 ns after a rising edge of the first clock. The second clock toggles on its own 40 ns period, offset so that none of its edges meets an input change or a sample point. Outputs are sampled 1 ns after each falling edge of the first clock. At that point the second clock is sometimes high and sometimes low, so the latch on the second clock is seen both transparent and holding.

// File: rtl/io_cell.sv
module io_cell #(
  parameter int NCLK  = 2,
  parameter int NGOE  = 2,
  parameter int NPTOE = 10,
  parameter int SEL_W = 4
) (
  input  logic [NCLK-1:0]          io_clk,
  input  logic                     rst_n,
  input  logic                     test_oe_n,
  input  logic [NGOE-1:0]          goe,
  input  logic [NPTOE-1:0]         pt_oe,
  input  logic [2:0]               cfg_mode,
  input  logic [SEL_W-1:0]         cfg_oe_sel,
  input  logic [$clog2(NCLK)-1:0]  cfg_clk_sel,
  input  logic                     pad_i,
  output logic                     pad_o,
  output logic                     pad_oe,
  input  logic                     core_out,
  output logic                     core_in
);

  localparam int NSRC = NGOE + NPTOE;
  localparam logic [2:0] M_COMB  = 3'd0;
  localparam logic [2:0] M_REG   = 3'd1;
  localparam logic [2:0] M_LATCH = 3'd2;
  localparam logic [2:0] M_OUT   = 3'd3;
  localparam logic [2:0] M_BIDIR = 3'd4;

  logic [NSRC-1:0] oe_src;
  logic [NCLK-1:0] reg_q;
  logic [NCLK-1:0] lat_q;
  logic            oe_pick;
  logic            drive;

  assign oe_src = {pt_oe, goe};

  for (genvar g = 0; g < NCLK; g++) begin : g_clk
    logic r;
    logic l;
    always_ff @(posedge io_clk[g] or negedge rst_n) begin
      if (!rst_n) r <= 1'b0;
      else        r <= pad_i;
    end
    always_latch begin
      if (!rst_n)         l = 1'b0;
      else if (io_clk[g]) l = pad_i;
    end
    assign reg_q[g] = r;
    assign lat_q[g] = l;
  end

  always_comb begin
    oe_pick = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (int'(cfg_oe_sel) == i) oe_pick = oe_src[i];
  end

  always_comb begin
    case (cfg_mode)
      M_OUT:   drive = 1'b1;
      M_BIDIR: drive = oe_pick;
      default: drive = 1'b0;
    endcase
  end

  assign pad_oe = test_oe_n & drive;
  assign pad_o  = pad_oe & core_out;

  always_comb begin
    case (cfg_mode)
      M_REG:   core_in = reg_q[cfg_clk_sel];
      M_LATCH: core_in = lat_q[cfg_clk_sel];
      M_OUT:   core_in = 1'b0;
      default: core_in = pad_i;
    endcase
  end

endmodule

// File: rtl/io_cell_chk.sv
module io_cell_chk #(
  parameter int NCLK  = 2,
  parameter int NGOE  = 2,
  parameter int NPTOE = 10,
  parameter int SEL_W = 4
) (
  input logic [NCLK-1:0]         io_clk,
  input logic                    rst_n,
  input logic                    test_oe_n,
  input logic [2:0]              cfg_mode,
  input logic [SEL_W-1:0]        cfg_oe_sel,
  input logic [$clog2(NCLK)-1:0] cfg_clk_sel,
  input logic                    pad_i,
  input logic                    pad_o,
  input logic                    pad_oe,
  input logic                    core_out,
  input logic                    core_in
);

  localparam int NSRC = NGOE + NPTOE;

  AST_TEST_OE_WINS: assert property (@(posedge io_clk[0]) disable iff (!rst_n)
    !test_oe_n |-> !pad_oe); // R8

  AST_INPUT_NO_DRIVE: assert property (@(posedge io_clk[0]) disable iff (!rst_n)
    (cfg_mode <= 3'd2 || cfg_mode >= 3'd5) |-> !pad_oe); // R1

  AST_OUTPUT_DRIVES: assert property (@(posedge io_clk[0]) disable iff (!rst_n)
    (cfg_mode == 3'd3 && test_oe_n) |-> (pad_oe && core_in == 1'b0)); // R5

  AST_SEL_HIGH_OFF: assert property (@(posedge io_clk[0]) disable iff (!rst_n)
    (cfg_mode == 3'd4 && int'(cfg_oe_sel) >= NSRC) |-> !pad_oe); // R6

  AST_PAD_QUIET: assert property (@(posedge io_clk[0]) disable iff (!rst_n)
    !pad_oe |-> !pad_o); // R9

  AST_PAD_FOLLOWS: assert property (@(posedge io_clk[0]) disable iff (!rst_n)
    pad_oe |-> (pad_o == core_out)); // R9

  AST_BIDIR_FEEDBACK: assert property (@(posedge io_clk[0]) disable iff (!rst_n)
    cfg_mode == 3'd4 |-> core_in == pad_i); // R7

  AST_REG_CAPTURE: assert property (@(posedge io_clk[0]) disable iff (!rst_n)
    ($past(rst_n) && $past(cfg_mode) == 3'd1 && $past(cfg_clk_sel) == '0
     && cfg_mode == 3'd1 && cfg_clk_sel == '0) |-> core_in == $past(pad_i)); // R2

endmodule

bind io_cell io_cell_chk #(.NCLK(NCLK), .NGOE(NGOE), .NPTOE(NPTOE), .SEL_W(SEL_W)) u_chk (
  .io_clk(io_clk), .rst_n(rst_n), .test_oe_n(test_oe_n), .cfg_mode(cfg_mode),
  .cfg_oe_sel(cfg_oe_sel), .cfg_clk_sel(cfg_clk_sel), .pad_i(pad_i),
  .pad_o(pad_o), .pad_oe(pad_oe), .core_out(core_out), .core_in(core_in)
);

// File: tb/io_cell_test.sv
module io_cell_test;

  logic        clk0 = 1'b0;
  logic        clk1 = 1'b0;
  logic        rst_n = 1'b0;
  logic        test_oe_n = 1'b1;
  logic [1:0]  goe = '0;
  logic [9:0]  pt_oe = '0;
  logic [2:0]  cfg_mode = 3'd1;
  logic [3:0]  cfg_oe_sel = '0;
  logic [0:0]  cfg_clk_sel = '0;
  logic        pad_i = 1'b0;
  logic        core_out = 1'b0;
  logic        pad_o, pad_oe, core_in;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  io_cell uut (
    .io_clk({clk1, clk0}), .rst_n(rst_n), .test_oe_n(test_oe_n), .goe(goe),
    .pt_oe(pt_oe), .cfg_mode(cfg_mode), .cfg_oe_sel(cfg_oe_sel),
    .cfg_clk_sel(cfg_clk_sel), .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe),
    .core_out(core_out), .core_in(core_in)
  );

  always #5 clk0 = ~clk0;
  initial begin
    #8;
    forever #20 clk1 = ~clk1;
  end

  // reference storage: value at last rising edge, value at last falling edge
  bit m_rise [2];
  bit m_fall [2];
  always @(posedge clk0 or negedge rst_n) m_rise[0] <= rst_n ? pad_i : 1'b0;
  always @(posedge clk1 or negedge rst_n) m_rise[1] <= rst_n ? pad_i : 1'b0;
  always @(negedge clk0 or negedge rst_n) m_fall[0] <= rst_n ? pad_i : 1'b0;
  always @(negedge clk1 or negedge rst_n) m_fall[1] <= rst_n ? pad_i : 1'b0;

  task automatic check(input string tag);
    bit e_oe, e_po, e_ci, ck;
    int s;
    e_oe = 0;
    s = int'(cfg_oe_sel);
    if (cfg_mode == 3'd3) e_oe = 1;
    if (cfg_mode == 3'd4) begin
      if (s < 2)       e_oe = goe[s];
      else if (s < 12) e_oe = pt_oe[s-2];
    end
    if (!test_oe_n) e_oe = 0;
    e_po = e_oe ? core_out : 1'b0;
    ck = cfg_clk_sel[0] ? clk1 : clk0;
    case (cfg_mode)
      3'd1: e_ci = rst_n ? m_rise[cfg_clk_sel] : 1'b0;
      3'd2: e_ci = !rst_n ? 1'b0 : (ck ? pad_i : m_fall[cfg_clk_sel]);
      3'd3: e_ci = 1'b0;
      default: e_ci = pad_i;
    endcase
    vecs++;
    if (pad_oe !== e_oe || pad_o !== e_po || core_in !== e_ci) begin
      errs++;
      $display("FAIL %s mode=%0d sel=%0d: oe/pad_o/core_in got %b%b%b expected %b%b%b",
               tag, cfg_mode, cfg_oe_sel, pad_oe, pad_o, core_in, e_oe, e_po, e_ci);
    end
  endtask

  task automatic vec(input string tag, input bit [2:0] m, input bit cs,
                     input bit [3:0] os, input bit toe);
    @(posedge clk0);
    #1;
    cfg_mode = m; cfg_clk_sel = cs; cfg_oe_sel = os; test_oe_n = toe;
    pad_i = 1'($urandom); core_out = 1'($urandom);
    goe = 2'($urandom); pt_oe = 10'($urandom);
    @(negedge clk0);
    #1;
    check(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errs++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    finish_run();
  end

  initial begin
    // R10: reset state, register mode with pad high
    pad_i = 1'b1;
    @(negedge clk0); #1; check("R10 reset reg");
    cfg_mode = 3'd2; #1; check("R10 reset latch");
    repeat (2) @(posedge clk0);
    #1 rst_n = 1'b1;

    for (int i = 0; i < 20; i++) vec("R1 comb input", 3'd0, 1'(i), 4'(i), 1);
    for (int i = 0; i < 12; i++) vec("R11 spare modes", 3'(5 + i % 3), 1'(i), 4'(i), 1);
    for (int i = 0; i < 24; i++) vec("R2 reg clk0", 3'd1, 0, 0, 1);
    for (int i = 0; i < 24; i++) vec("R4 reg clk1", 3'd1, 1, 0, 1);
    for (int i = 0; i < 24; i++) vec("R3 latch clk0", 3'd2, 0, 0, 1);
    for (int i = 0; i < 32; i++) vec("R3 latch clk1", 3'd2, 1, 0, 1);
    for (int i = 0; i < 16; i++) vec("R4 clock select toggle", 3'(1 + i % 2), 1'(i / 2), 0, 1);
    for (int i = 0; i < 16; i++) vec("R5 output", 3'd3, 1'(i), 4'(i), 1);
    for (int r = 0; r < 4; r++)
      for (int s = 0; s < 16; s++) vec("R6 oe select", 3'd4, 0, 4'(s), 1);
    for (int i = 0; i < 20; i++) vec("R7 bidir feedback", 3'd4, 0, 4'(i % 12), 1);
    for (int m = 0; m < 8; m++)
      for (int s = 0; s < 16; s += 3) vec("R8 test oe", 3'(m), 1'(s), 4'(s), 0);
    for (int i = 0; i < 24; i++) vec("R9 pad data", 3'(3 + i % 2), 0, 4'(i % 16), 1);

    // R10: reset during operation clears storage without a clock edge
    vec("R10 pre", 3'd1, 0, 0, 1);
    pad_i = 1'b1;
    vec("R10 load", 3'd1, 1, 0, 1);
    @(posedge clk0); #1; pad_i = 1'b1; rst_n = 1'b0;
    #1; check("R10 async reg");
    cfg_mode = 3'd2; cfg_clk_sel = 1'b0; #1; check("R10 async latch");
    @(posedge clk0); #1 rst_n = 1'b1;

    for (int i = 0; i < 300; i++)
      vec("R1-mix random", 3'($urandom), 1'($urandom), 4'($urandom), ($urandom % 6) != 0);

    finish_run();
  end

endmodule